// File: doc/BRIEF.md
# Multi-channel power fault supervisor

This block is the digital protection controller of a six-channel switching regulator. It receives comparator results that are already digital, but not synchronous to its clock: a supply-undervoltage flag, an input-overvoltage flag, an overtemperature flag, and per-channel output-low, output-overvoltage and overcurrent flags. It also receives one enable input per channel. From these it produces a high-side and a low-side gate enable for each channel, a current-limit request for each channel, and a status vector that shows which fault sources are active.

The supply-undervoltage, input-overvoltage, overtemperature and output-overvoltage faults are non-latching. Each one holds the switches off only while its flag is present. A sustained output-low condition on any running channel is timed by a short-circuit counter whose length is a parameter in clock cycles. When the counter expires, a latched shutdown stops every channel. The latch is released either by turning every channel enable off and then turning at least one back on, or by a supply-undervoltage pulse. An output overvoltage is treated differently on one designated channel (the fourth, index 3): its low-side enable is held on instead of off, so that the output is discharged.

Every flag and every enable input passes through a two-flop synchronizer. All outputs are registered. A change on an input therefore reaches the outputs at the third rising clock edge after it is applied.

Top module: `pfs_top`

## Requirements
- R1: While the supply-undervoltage flag is high, every high-side and low-side enable is 0. When the flag drops, the outputs follow the enables again, with no latch.
- R2: While the input-overvoltage flag is high, every high-side and low-side enable is 0. The fault clears by itself when the flag drops.
- R3: While the overtemperature flag is high, every high-side and low-side enable is 0. The fault clears by itself when the flag drops.
- R4: The short-circuit counter runs when all of the following hold: some output-low flag is high, at least one enable input is high, and supply undervoltage is absent. After SC_CYCLES consecutive synchronized cycles in that condition the short-circuit latch sets. The latch forces every switch enable to 0 and stays set after the output-low flags clear.
- R5: If every output-low flag drops before the timeout, the counter returns to zero. A later output-low episode shorter than SC_CYCLES therefore does not set the latch.
- R6: The short-circuit latch clears when all six enable inputs are low and then at least one is raised again. Changing the enables while at least one of them stays high does not clear the latch.
- R7: The short-circuit latch clears when the supply-undervoltage flag rises and then falls.
- R8: When any channel's overvoltage flag is high and no other fault is active (undervoltage, input overvoltage, overtemperature, short-circuit latch), all high-side enables are 0 and the low-side enables equal one-hot bit SPECIAL_CH (default 3, vector value 0x08). This holds whatever the enable inputs are. When undervoltage, input overvoltage, overtemperature or the short-circuit latch is also active, all enables are 0. The overvoltage fault clears by itself when the flag drops.
- R9: An overcurrent flag on channel i raises only ilim_req bit i. It does not change any gate enable.
- R10: With no fault active, hs_en and ls_en of each channel equal that channel's enable input. The delay is three rising edges.
- R11: fault_stat bit 0 is undervoltage, bit 1 is input overvoltage, bit 2 is overtemperature, bit 3 is the OR of the channel overvoltage flags, and bit 4 is the short-circuit latch. Each bit is delayed like the gate enables.
- R12: While reset is high and after it is released, the latch is clear, the counter is zero, and all outputs are 0 until inputs propagate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_flag | input | 1 | Supply undervoltage flag (asynchronous) |
| iv_flag | input | 1 | Input overvoltage flag (asynchronous) |
| ot_flag | input | 1 | Overtemperature flag (asynchronous) |
| vlow_flag | input | NCH | Per-channel output-low flags |
| ovp_flag | input | NCH | Per-channel output-overvoltage flags |
| ocp_flag | input | NCH | Per-channel overcurrent flags |
| ch_en | input | NCH | Per-channel enable inputs |
| hs_en | output | NCH | High-side gate enables |
| ls_en | output | NCH | Low-side gate enables |
| ilim_req | output | NCH | Per-channel current-limit requests |
| fault_stat | output | 5 | Fault status, bit map in R11 |

## Verification
On every cycle, the assertions check that the gate enables agree with the reported status. Any of undervoltage, input overvoltage, overtemperature or the short-circuit latch must coincide with all switches off. An overvoltage alone must coincide with only the designated low-side switch on. The timed behaviour can only be shown by the bench scenarios, which compare against a cycle-accurate reference model: the counter reaching or not reaching its limit, the counter restarting after a short dip, and the two release sequences of the latch. The scenarios also show that an enable change which keeps one channel on does not release the latch, and that an overcurrent flag does not reach the gate enables.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int ST_UV = 0;
  localparam int ST_IV = 1;
  localparam int ST_OT = 2;
  localparam int ST_OV = 3;
  localparam int ST_SC = 4;
  localparam int ST_W  = 5;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pfs_sc_timer.sv
module pfs_sc_timer #(
  parameter int NCH       = 6,
  parameter int SC_CYCLES = 280000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] s_low,
  input  logic [NCH-1:0] s_en,
  input  logic           s_uv,
  output logic           latched
);
  localparam int CW = $clog2(SC_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SC_CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          prev_uv, prev_off;
  logic          all_off, run, release_now;

  assign all_off     = ~|s_en;
  assign run         = (|s_low) & ~all_off & ~s_uv & ~latched;
  assign release_now = (prev_uv & ~s_uv) | (prev_off & ~all_off);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      latched  <= 1'b0;
      prev_uv  <= 1'b0;
      prev_off <= 1'b0;
    end else begin
      prev_uv  <= s_uv;
      prev_off <= all_off;
      if (latched) begin
        cnt <= '0;
        if (release_now) latched <= 1'b0;
      end else if (!run) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        cnt     <= '0;
        latched <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfs_gate_ctrl.sv
module pfs_gate_ctrl
  import pfs_pkg::*;
#(
  parameter int NCH        = 6,
  parameter int SPECIAL_CH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCH-1:0]  s_en,
  input  logic [NCH-1:0]  s_ovp,
  input  logic [NCH-1:0]  s_ocp,
  input  logic            s_uv,
  input  logic            s_iv,
  input  logic            s_ot,
  input  logic            latched,
  output logic [NCH-1:0]  hs_en,
  output logic [NCH-1:0]  ls_en,
  output logic [NCH-1:0]  ilim_req,
  output logic [ST_W-1:0] fault_stat
);
  logic           any_ov, hard_off;
  logic [NCH-1:0] hs_d, ls_d;

  assign any_ov   = |s_ovp;
  assign hard_off = s_uv | s_iv | s_ot | latched;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      if (hard_off) begin
        hs_d[i] = 1'b0;
        ls_d[i] = 1'b0;
      end else if (any_ov) begin
        hs_d[i] = 1'b0;
        ls_d[i] = (i == SPECIAL_CH);
      end else begin
        hs_d[i] = s_en[i];
        ls_d[i] = s_en[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_en      <= '0;
      ls_en      <= '0;
      ilim_req   <= '0;
      fault_stat <= '0;
    end else begin
      hs_en      <= hs_d;
      ls_en      <= ls_d;
      ilim_req   <= s_ocp;
      fault_stat <= {latched, any_ov, s_ot, s_iv, s_uv};
    end
  end
endmodule

// File: rtl/pfs_top.sv
module pfs_top
  import pfs_pkg::*;
#(
  parameter int NCH        = 6,
  parameter int SC_CYCLES  = 280000,
  parameter int SPECIAL_CH = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            uv_flag,
  input  logic            iv_flag,
  input  logic            ot_flag,
  input  logic [NCH-1:0]  vlow_flag,
  input  logic [NCH-1:0]  ovp_flag,
  input  logic [NCH-1:0]  ocp_flag,
  input  logic [NCH-1:0]  ch_en,
  output logic [NCH-1:0]  hs_en,
  output logic [NCH-1:0]  ls_en,
  output logic [NCH-1:0]  ilim_req,
  output logic [ST_W-1:0] fault_stat
);
  localparam int SW = 3 + 4 * NCH;

  logic [SW-1:0]  raw_v, syn_v;
  logic [NCH-1:0] s_low, s_ovp, s_ocp, s_en;
  logic           s_uv, s_iv, s_ot, latched;

  assign raw_v = {uv_flag, iv_flag, ot_flag, vlow_flag, ovp_flag, ocp_flag, ch_en};

  pfs_sync #(.W(SW)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );

  assign {s_uv, s_iv, s_ot, s_low, s_ovp, s_ocp, s_en} = syn_v;

  pfs_sc_timer #(.NCH(NCH), .SC_CYCLES(SC_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .s_low(s_low), .s_en(s_en), .s_uv(s_uv),
    .latched(latched)
  );

  pfs_gate_ctrl #(.NCH(NCH), .SPECIAL_CH(SPECIAL_CH)) u_gate (
    .clk(clk), .rst(rst), .s_en(s_en), .s_ovp(s_ovp), .s_ocp(s_ocp),
    .s_uv(s_uv), .s_iv(s_iv), .s_ot(s_ot), .latched(latched),
    .hs_en(hs_en), .ls_en(ls_en), .ilim_req(ilim_req), .fault_stat(fault_stat)
  );
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
  import pfs_pkg::*;
#(
  parameter int NCH        = 6,
  parameter int SPECIAL_CH = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [NCH-1:0]  hs_en,
  input logic [NCH-1:0]  ls_en,
  input logic [ST_W-1:0] fault_stat
);
  localparam logic [NCH-1:0] SPEC_MASK = NCH'(1) << SPECIAL_CH;

  a_r1_uv_all_off: assert property (@(posedge clk) disable iff (rst)
    fault_stat[ST_UV] |-> (hs_en == '0 && ls_en == '0));

  a_r2_iv_all_off: assert property (@(posedge clk) disable iff (rst)
    fault_stat[ST_IV] |-> (hs_en == '0 && ls_en == '0));

  a_r3_ot_all_off: assert property (@(posedge clk) disable iff (rst)
    fault_stat[ST_OT] |-> (hs_en == '0 && ls_en == '0));

  a_r4_sc_all_off: assert property (@(posedge clk) disable iff (rst)
    fault_stat[ST_SC] |-> (hs_en == '0 && ls_en == '0));

  a_r8_ov_special: assert property (@(posedge clk) disable iff (rst)
    (fault_stat[ST_OV] && !fault_stat[ST_UV] && !fault_stat[ST_IV] &&
     !fault_stat[ST_OT] && !fault_stat[ST_SC])
    |-> (hs_en == '0 && ls_en == SPEC_MASK));
endmodule

bind pfs_top pfs_checker #(.NCH(NCH), .SPECIAL_CH(SPECIAL_CH)) u_pfs_chk (
  .clk(clk), .rst(rst), .hs_en(hs_en), .ls_en(ls_en), .fault_stat(fault_stat)
);

// File: tb/test_pfs_top.sv
module test_pfs_top;
  localparam int NCH = 6;
  localparam int SCC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv = 0, iv = 0, ot = 0;
  logic [NCH-1:0] vlow = '0, ovp = '0, ocp = '0, en = '0;
  logic [NCH-1:0] hs, ls, il;
  logic [4:0] st;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pfs_top #(.NCH(NCH), .SC_CYCLES(SCC), .SPECIAL_CH(3)) i_pfs_top (
    .clk(clk), .rst(rst), .uv_flag(uv), .iv_flag(iv), .ot_flag(ot),
    .vlow_flag(vlow), .ovp_flag(ovp), .ocp_flag(ocp), .ch_en(en),
    .hs_en(hs), .ls_en(ls), .ilim_req(il), .fault_stat(st)
  );

  // behavioural reference: two-deep input delay, timer integer, latch bit
  logic [3+4*NCH-1:0] d1, d2;
  int  m_cnt;
  bit  m_lat, m_puv, m_poff;
  logic [NCH-1:0] e_hs, e_ls, e_il;
  logic [4:0] e_st;

  always @(posedge clk) begin
    if (rst) begin
      d1 = '0; d2 = '0; m_cnt = 0; m_lat = 0; m_puv = 0; m_poff = 0;
      e_hs = '0; e_ls = '0; e_il = '0; e_st = '0;
    end else begin
      logic xuv, xiv, xot;
      logic [NCH-1:0] xlow, xov, xoc, xen;
      {xuv, xiv, xot, xlow, xov, xoc, xen} = d2;
      // outputs from the previous latch state
      if (xuv || xiv || xot || m_lat) begin e_hs = '0; e_ls = '0; end
      else if (xov != 0) begin e_hs = '0; e_ls = 6'h08; end
      else begin e_hs = xen; e_ls = xen; end
      e_il = xoc;
      e_st = {m_lat, (xov != 0), xot, xiv, xuv};
      // short-circuit timing and release
      if (m_lat) begin
        m_cnt = 0;
        if ((m_puv && !xuv) || (m_poff && xen != 0)) m_lat = 0;
      end else if (xlow != 0 && xen != 0 && !xuv) begin
        m_cnt++;
        if (m_cnt >= SCC) begin m_lat = 1; m_cnt = 0; end
      end else m_cnt = 0;
      m_puv = xuv; m_poff = (xen == 0);
      d2 = d1;
      d1 = {uv, iv, ot, vlow, ovp, ocp, en};
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (hs !== e_hs || ls !== e_ls) begin
        failures++;
        $display("FAIL R10 model gates hs=%h ls=%h expected hs=%h ls=%h", hs, ls, e_hs, e_ls);
      end
      if (il !== e_il) begin
        failures++;
        $display("FAIL R9 model ilim=%h expected %h", il, e_il);
      end
      if (st !== e_st) begin
        failures++;
        $display("FAIL R11 model stat=%h expected %h", st, e_st);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    wcyc(3);
    chk("R12 reset hs", 16'(hs), 16'h0);
    chk("R12 reset stat", 16'(st), 16'h0);
    @(negedge clk) rst = 0;
    wcyc(2);
    chk("R12 after reset ls", 16'(ls), 16'h0);

    en = 6'h3F; wcyc(5);
    chk("R10 all enabled hs", 16'(hs), 16'h3F);
    en = 6'h05; wcyc(5);
    chk("R10 partial ls", 16'(ls), 16'h05);

    uv = 1; wcyc(5);
    chk("R1 uv hs", 16'(hs), 16'h0);
    chk("R11 uv stat", 16'(st), 16'h01);
    uv = 0; wcyc(5);
    chk("R1 uv recover", 16'(hs), 16'h05);

    iv = 1; wcyc(5);
    chk("R2 iv ls", 16'(ls), 16'h0);
    chk("R11 iv stat", 16'(st), 16'h02);
    iv = 0; wcyc(5);
    chk("R2 iv recover", 16'(hs), 16'h05);

    ot = 1; wcyc(5);
    chk("R3 ot hs", 16'(hs), 16'h0);
    chk("R11 ot stat", 16'(st), 16'h04);
    ot = 0; wcyc(5);
    chk("R3 ot recover", 16'(ls), 16'h05);

    ocp = 6'h04; wcyc(5);
    chk("R9 ilim", 16'(il), 16'h04);
    chk("R9 gates untouched", 16'(hs), 16'h05);
    ocp = '0;

    ovp = 6'h01; wcyc(5);
    chk("R8 ov hs", 16'(hs), 16'h0);
    chk("R8 ov special ls", 16'(ls), 16'h08);
    chk("R11 ov stat", 16'(st), 16'h08);
    uv = 1; wcyc(5);
    chk("R8 ov with uv ls", 16'(ls), 16'h0);
    uv = 0; ovp = '0; wcyc(5);
    chk("R8 ov recover", 16'(hs), 16'h05);

    vlow = 6'h02; wcyc(10); vlow = '0; wcyc(6);
    vlow = 6'h20; wcyc(10); vlow = '0; wcyc(6);
    chk("R5 short dips no latch", 16'(st), 16'h00);
    chk("R5 gates on", 16'(hs), 16'h05);

    vlow = 6'h02; wcyc(25);
    chk("R4 latched stat", 16'(st), 16'h10);
    chk("R4 latched hs", 16'(hs), 16'h0);
    vlow = '0; wcyc(8);
    chk("R4 latch holds", 16'(st), 16'h10);
    en = 6'h01; wcyc(6);
    chk("R6 partial change no release", 16'(st), 16'h10);
    en = 6'h00; wcyc(5); en = 6'h05; wcyc(6);
    chk("R6 release stat", 16'(st), 16'h00);
    chk("R6 release hs", 16'(hs), 16'h05);

    vlow = 6'h08; wcyc(25); vlow = '0; wcyc(4);
    chk("R4 relatched", 16'(st), 16'h10);
    uv = 1; wcyc(5); uv = 0; wcyc(6);
    chk("R7 uv release stat", 16'(st), 16'h00);
    chk("R7 uv release ls", 16'(ls), 16'h05);

    wcyc(3);
    done = 1;
    summary();
  end
endmodule